// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by walking a two-level translation table kept in memory. The linear address is cut into a directory index, a table index and a byte offset within a 4 KB page. Starting from a directory base supplied by a control register, the walker fetches the directory entry and then the table entry. It joins the frame number of the table entry with the offset. A clear present bit in either entry ends the walk with a fault instead of a result.

The walker has a single outstanding translation. A requester offers an address while the block signals that it is free. The walker then issues up to two dependent reads on a simple read port, holding each request until the memory answers with a valid word. The outcome appears as a one-cycle done or fault pulse together with an address. When translation is switched off, the linear address comes back unchanged one cycle after acceptance, and no memory read is made.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held and directly after it, `xlate_ready` is 1 and `res_done`, `res_fault` and `mem_rd_req` are 0.
- R2: A translation is accepted only on a clock edge where `xlate_req` and `xlate_ready` are both 1. `xlate_ready` is 0 from the edge after acceptance until the walk has ended. A request offered while busy has no effect on the running walk's reads or result.
- R3: If `cfg_paging_en` is 0 at acceptance, `res_done` is 1 in the next cycle with `res_phys` equal to the accepted linear address, and no memory read is issued.
- R4: The first read goes to `{cfg_dir_base[31:12], 12'h000} + lin[31:22]*4`. A read request stays asserted with a stable address until a cycle in which `mem_rd_valid` is 1.
- R5: Bit 0 of each entry is its present bit. If the directory entry has bit 0 set, the second read goes to `{pde[31:12], 12'h000} + lin[21:12]*4`. If bit 0 is clear, the walk ends in a fault and makes no second read.
- R6: If the table entry has bit 0 set, `res_done` pulses for one cycle with `res_phys = {pte[31:12], lin[11:0]}`.
- R7: If the table entry has bit 0 clear, `res_fault` pulses for one cycle instead of `res_done`. On any fault, `res_phys` equals the linear address that faulted.
- R8: `res_done` and `res_fault` are never 1 together. Each lasts exactly one cycle, and `xlate_ready` is 1 in the following cycle.
- R9: `cfg_dir_base` and `cfg_paging_en` are sampled at acceptance. Changing them during a walk does not alter that walk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_paging_en | input | 1 | Translation enable control bit |
| cfg_dir_base | input | 32 | Directory base control register (bits 31:12 used) |
| xlate_req | input | 1 | Translation request |
| xlate_lin | input | 32 | Linear address to translate |
| xlate_ready | output | 1 | Walker idle, request can be taken |
| mem_rd_req | output | 1 | Memory read request, held until answered |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Entry word returned by memory |
| res_done | output | 1 | Translation completed (one-cycle pulse) |
| res_fault | output | 1 | Walk stopped on a non-present entry (one-cycle pulse) |
| res_phys | output | 32 | Physical address, or faulting linear address |

## Verification
The overlap of interest is a fresh translation request arriving while a walk is still in flight, including the very cycle in which the result pulse is shown. On selected walks the bench keeps `xlate_req` high with a different address, the opposite enable and a different directory base from the first cycle after acceptance through the result cycle. It then checks that the issued read addresses and the result still follow the original request, and that exactly one result pulse appears. The memory answers with a random latency of zero to three cycles, so the interference lands on every phase of the walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   typedef enum logic [2:0] {
      WALK_IDLE  = 3'd0,
      WALK_DIR   = 3'd1,
      WALK_TBL   = 3'd2,
      WALK_DONE  = 3'd3,
      WALK_FAULT = 3'd4
   } walk_state_e;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
   parameter int ADDR_W      = 32,
   parameter int OFF_W       = 12,
   parameter int IDX_W       = 10,
   parameter int ENTRY_BYTES = 4
) (
   input  logic [ADDR_W-OFF_W-1:0] frame,
   input  logic [IDX_W-1:0]        idx,
   output logic [ADDR_W-1:0]       entry_addr
);
   localparam int SH  = $clog2(ENTRY_BYTES);
   localparam int PAD = ADDR_W - IDX_W - SH;

   initial begin
      assert (ENTRY_BYTES == (1 << SH))
         else $error("entry size must be a power of two");
      assert (PAD > 0)
         else $error("index does not fit the address width");
   end

   logic [ADDR_W-1:0] table_start;
   logic [ADDR_W-1:0] idx_bytes;

   assign table_start = {frame, {OFF_W{1'b0}}};

   generate
      if (SH == 0) begin : g_byte_entries
         assign idx_bytes = {{PAD{1'b0}}, idx};
      end else begin : g_wide_entries
         assign idx_bytes = {{PAD{1'b0}}, idx, {SH{1'b0}}};
      end
   endgenerate

   assign entry_addr = table_start + idx_bytes;
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
   import ptw_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        bypass,
   input  logic        rd_valid,
   input  logic        present,
   output walk_state_e state
);
   walk_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         WALK_IDLE:  if (start) nxt = bypass ? WALK_DONE : WALK_DIR;
         WALK_DIR:   if (rd_valid) nxt = present ? WALK_TBL : WALK_FAULT;
         WALK_TBL:   if (rd_valid) nxt = present ? WALK_DONE : WALK_FAULT;
         WALK_DONE:  nxt = WALK_IDLE;
         WALK_FAULT: nxt = WALK_IDLE;
         default:    nxt = WALK_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= WALK_IDLE;
      else        state <= nxt;
   end

   p_walk_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WALK_TBL) |-> ($past(state) == WALK_DIR || $past(state) == WALK_TBL));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DIR_W       = 10,
   parameter int TBL_W       = 10,
   parameter int OFF_W       = 12,
   parameter int ENTRY_BYTES = 4,
   parameter int PRESENT_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_paging_en,
   input  logic [ADDR_W-1:0] cfg_dir_base,
   input  logic              xlate_req,
   input  logic [ADDR_W-1:0] xlate_lin,
   output logic              xlate_ready,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_valid,
   input  logic [ADDR_W-1:0] mem_rd_data,
   output logic              res_done,
   output logic              res_fault,
   output logic [ADDR_W-1:0] res_phys
);
   localparam int FRAME_W = ADDR_W - OFF_W;
   localparam int TBL_LO  = OFF_W;
   localparam int DIR_LO  = OFF_W + TBL_W;

   generate
      if (DIR_W + TBL_W + OFF_W != ADDR_W) begin : g_bad_split
         $error("index and offset widths must add up to the address width");
      end
      if (PRESENT_BIT >= OFF_W) begin : g_bad_present
         $error("present bit must lie below the frame field");
      end
   endgenerate

   walk_state_e state;
   logic [ADDR_W-1:0]  lin_q;
   logic [FRAME_W-1:0] dir_frame_q;
   logic [FRAME_W-1:0] tbl_frame_q;
   logic [ADDR_W-1:0]  phys_q;
   logic [ADDR_W-1:0]  dir_entry_addr;
   logic [ADDR_W-1:0]  tbl_entry_addr;
   logic               accept;
   logic               present;
   logic               unused_low_bits;

   assign accept          = xlate_req && xlate_ready;
   assign present         = mem_rd_data[PRESENT_BIT];
   assign unused_low_bits = ^{mem_rd_data[OFF_W-1:0], cfg_dir_base[OFF_W-1:0]};

   ptw_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .bypass   (!cfg_paging_en),
      .rd_valid (mem_rd_valid),
      .present  (present),
      .state    (state)
   );

   ptw_entry_addr #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(DIR_W), .ENTRY_BYTES(ENTRY_BYTES)
   ) u_dir_addr (
      .frame      (dir_frame_q),
      .idx        (lin_q[ADDR_W-1:DIR_LO]),
      .entry_addr (dir_entry_addr)
   );

   ptw_entry_addr #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(TBL_W), .ENTRY_BYTES(ENTRY_BYTES)
   ) u_tbl_addr (
      .frame      (tbl_frame_q),
      .idx        (lin_q[DIR_LO-1:TBL_LO]),
      .entry_addr (tbl_entry_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lin_q       <= '0;
         dir_frame_q <= '0;
         tbl_frame_q <= '0;
         phys_q      <= '0;
      end else begin
         if (accept) begin
            lin_q       <= xlate_lin;
            dir_frame_q <= cfg_dir_base[ADDR_W-1:OFF_W];
            if (!cfg_paging_en) phys_q <= xlate_lin;
         end
         if (state == WALK_DIR && mem_rd_valid) begin
            tbl_frame_q <= mem_rd_data[ADDR_W-1:OFF_W];
            if (!present) phys_q <= lin_q;
         end
         if (state == WALK_TBL && mem_rd_valid) begin
            phys_q <= present ? {mem_rd_data[ADDR_W-1:OFF_W], lin_q[OFF_W-1:0]} : lin_q;
         end
      end
   end

   assign xlate_ready = (state == WALK_IDLE);
   assign mem_rd_req  = (state == WALK_DIR) || (state == WALK_TBL);
   assign mem_rd_addr = (state == WALK_TBL) ? tbl_entry_addr : dir_entry_addr;
   assign res_done    = (state == WALK_DONE);
   assign res_fault   = (state == WALK_FAULT);
   assign res_phys    = phys_q;

   p_busy_no_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> !xlate_ready);

   p_bypass_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (xlate_req && xlate_ready && !cfg_paging_en) |=>
         (res_done && res_phys == $past(xlate_lin)));

   p_read_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

   p_fault_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(res_fault) |-> ($past(mem_rd_valid) && !$past(present)));

   p_result_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_done && res_fault));

   p_result_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_done || res_fault) |=> (xlate_ready && !res_done && !res_fault));
endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_paging_en = 1'b0;
   logic [31:0] cfg_dir_base = '0;
   logic        xlate_req = 1'b0;
   logic [31:0] xlate_lin = '0;
   logic        xlate_ready;
   logic        mem_rd_req;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_valid = 1'b0;
   logic [31:0] mem_rd_data = '0;
   logic        res_done;
   logic        res_fault;
   logic [31:0] res_phys;

   int n_checks = 0;
   int n_fail   = 0;
   int n_reads  = 0;
   logic [31:0] rd_log [0:3];
   int lat_left = -1;
   int cycles   = 0;
   bit finished = 0;

   always #2ns clk = ~clk;

   ptw_walker dut (
      .clk(clk), .rst_n(rst_n), .cfg_paging_en(cfg_paging_en),
      .cfg_dir_base(cfg_dir_base), .xlate_req(xlate_req), .xlate_lin(xlate_lin),
      .xlate_ready(xlate_ready), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .res_done(res_done), .res_fault(res_fault), .res_phys(res_phys)
   );

   // Memory contents: a few fixed words for directed cases, a hash elsewhere.
   function automatic logic [31:0] mem_word(input logic [31:0] a);
      logic [31:0] h;
      case (a)
         32'h0000_1000: return 32'h0000_2001;
         32'h0000_2000: return 32'h0010_0001;
         32'h0000_1004: return 32'h0000_5001;
         32'h0000_5000: return 32'h0000_0000;
         32'h0000_3000: return 32'hABCD_E000;
         default: begin
            h = (a * 32'h9E37_79B1) ^ (a >> 7) ^ 32'h5A5A_1234;
            h[0] = (h[5:3] != 3'd0);
            return h;
         end
      endcase
   endfunction

   function automatic logic [31:0] entry_at(input logic [31:0] frame_word,
                                            input logic [9:0] idx);
      return {frame_word[31:12], 12'h000} + {20'd0, idx, 2'b00};
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // Memory responder: answers a held request after 0..3 cycles.
   initial begin
      forever begin
         @(negedge clk);
         if (mem_rd_valid) begin
            mem_rd_valid = 1'b0;
            lat_left = -1;
         end else if (mem_rd_req) begin
            if (lat_left < 0) lat_left = int'($urandom % 4);
            if (lat_left == 0) begin
               mem_rd_valid = 1'b1;
               mem_rd_data  = mem_word(mem_rd_addr);
               if (n_reads < 4) rd_log[n_reads] = mem_rd_addr;
               n_reads++;
            end else begin
               lat_left--;
            end
         end
      end
   end

   task automatic run_walk(input logic [31:0] lin, input logic [31:0] base,
                           input bit pg, input bit stray);
      logic [31:0] pde, pte, a0, a1, exp_phys;
      bit exp_fault;
      int exp_reads;
      int wait_cyc;
      a0 = entry_at(base, lin[31:22]);
      a1 = '0;
      pde = '0; pte = '0;
      if (!pg) begin
         exp_reads = 0; exp_fault = 0; exp_phys = lin;
      end else begin
         pde = mem_word(a0);
         if (!pde[0]) begin
            exp_reads = 1; exp_fault = 1; exp_phys = lin;
         end else begin
            a1 = entry_at(pde, lin[21:12]);
            pte = mem_word(a1);
            exp_reads = 2;
            exp_fault = !pte[0];
            exp_phys  = pte[0] ? {pte[31:12], lin[11:0]} : lin;
         end
      end

      @(negedge clk);
      check(xlate_ready, "R2 ready before request", 32'(xlate_ready), 32'd1);
      n_reads = 0;
      xlate_req = 1'b1; xlate_lin = lin; cfg_dir_base = base; cfg_paging_en = pg;
      @(posedge clk);
      @(negedge clk);
      if (stray) begin
         // R2 / R9: a conflicting request and changed controls during the walk
         xlate_lin = ~lin; cfg_dir_base = base ^ 32'h0040_3000; cfg_paging_en = !pg;
      end else begin
         xlate_req = 1'b0;
      end
      if (!pg) check(res_done, "R3 bypass result one cycle after accept",
                     32'(res_done), 32'd1);
      wait_cyc = 0;
      while (!(res_done || res_fault) && wait_cyc < 40) begin
         @(negedge clk);
         wait_cyc++;
      end
      xlate_req = 1'b0;
      check(!(res_done && res_fault), "R8 done and fault together",
            {30'd0, res_done, res_fault}, 32'd0);
      check(res_fault == exp_fault && res_done == !exp_fault,
            exp_fault ? "R5/R7 fault expected" : "R6 done expected",
            {30'd0, res_done, res_fault}, exp_fault ? 32'd1 : 32'd2);
      check(res_phys == exp_phys, exp_fault ? "R7 faulting address" : "R6 physical address",
            res_phys, exp_phys);
      check(n_reads == exp_reads, pg ? "R5 number of reads" : "R3 no read when bypassed",
            32'(n_reads), 32'(exp_reads));
      if (exp_reads >= 1 && n_reads >= 1)
         check(rd_log[0] == a0, "R4 directory entry address", rd_log[0], a0);
      if (exp_reads == 2 && n_reads >= 2)
         check(rd_log[1] == a1, "R5 table entry address", rd_log[1], a1);
      @(negedge clk);
      check(xlate_ready && !res_done && !res_fault, "R8 one-cycle pulse then ready",
            {29'd0, xlate_ready, res_done, res_fault}, 32'd4);
      check(n_reads == exp_reads, "R2 no read from ignored request",
            32'(n_reads), 32'(exp_reads));
   endtask

   initial begin
      void'($urandom(32'h00C0_FFEE));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(xlate_ready && !res_done && !res_fault && !mem_rd_req, "R1 state in reset",
            {28'd0, xlate_ready, res_done, res_fault, mem_rd_req}, 32'd8);
      rst_n = 1'b1;
      @(negedge clk);
      check(xlate_ready && !res_done && !res_fault && !mem_rd_req, "R1 state after reset",
            {28'd0, xlate_ready, res_done, res_fault, mem_rd_req}, 32'd8);

      // Directed corner cases
      run_walk(32'h0000_0ABC, 32'h0000_1000, 1'b1, 1'b0); // R6 slot 0/0 -> 0x00100ABC
      run_walk(32'h0000_0FFF, 32'h0000_1FFF, 1'b1, 1'b0); // R4 base low bits ignored
      run_walk(32'h0040_0123, 32'h0000_1000, 1'b1, 1'b0); // R7 table entry not present
      run_walk(32'h0000_0000, 32'h0000_3000, 1'b1, 1'b0); // R5 directory entry not present
      run_walk(32'hDEAD_BEEF, 32'h0000_1000, 1'b0, 1'b0); // R3 bypass
      run_walk(32'h0000_0ABC, 32'h0000_1000, 1'b1, 1'b1); // R2 R9 interference
      run_walk(32'h1234_5678, 32'h0000_1000, 1'b0, 1'b1); // R9 bypass with interference
      run_walk(32'hFFFF_FFFF, 32'hFFFF_F000, 1'b1, 1'b0); // R4 top indices

      // Constrained random walks
      for (int i = 0; i < 300; i++) begin
         logic [31:0] lin, base;
         bit pg, stray;
         lin   = $urandom;
         base  = $urandom;
         pg    = ($urandom % 8) != 0;
         stray = ($urandom % 4) == 0;
         run_walk(lin, base, pg, stray);
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      while (cycles < 150000) begin
         @(posedge clk);
         cycles++;
      end
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%08h expected=%08h", cycles, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule